// File: doc/BRIEF.md
# Nearest-Level Staircase Gate Controller

This block drives the fourteen power switches of a single-source, thirteen-level switched-capacitor boost inverter. It builds the staircase with nearest-level modulation. A phase accumulator advances by a programmable increment on every clock. A quarter-wave sine table supplies the reference, and quadrant symmetry rebuilds the full wave from it. The reference is scaled by a programmable amplitude and rounded to the nearest whole level between -6 and +6. Each gate therefore switches only at staircase steps at the fundamental rate, and no carrier is involved. For a 50 Hz reference the increment is 2^PHASE_W * 50 / f_clk.

The chosen level becomes a switching-state number. Positive levels use states 1 to 6, zero uses state 7, and negative levels use states 8 to 13, which mirror the positive ones. A writable 13-entry pattern table turns each state into a 14-bit gate vector, and the table can be read back. On every state change the gates that differ between the old and new patterns are held off for a programmable dead time. The new pattern is applied after that.

Top module: `staircase_gate_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `gateOut` is all zero, `stateOut` is 7 and `levelOut` is 0.
- R2: The phase register advances by `phaseInc` modulo 2^PHASE_W on every clock. Phase bits [PHASE_W-1:PHASE_W-2] select the quadrant and the next LUT_AW bits address the quarter-wave table. The address is mirrored in quadrants 1 and 3, and the sign is negative in quadrants 2 and 3.
- R3: The table magnitude is m = floor(2^(SAMP_W-1) * sin(pi*(2i+1)/(4*2^LUT_AW))) for address i. `levelOut` is registered one cycle after the phase. It is m*amplitude*6 / 2^(SAMP_W-1+AMP_W-1), rounded to the nearest integer with exact halves rounded away from zero, and then given the quadrant sign. An amplitude of 2^(AMP_W-1) is full scale.
- R4: A scaled magnitude above 6 saturates at 6, so `levelOut` never leaves -6..+6.
- R5: Level +k maps to state k, level 0 maps to state 7, and level -k maps to state 7+k, for k = 1..6. `stateOut` follows `levelOut` through the commit logic.
- R6: A write with `tblWe` high stores `tblWrData` at entry `tblAddr` on the clock edge, for addresses 1..13 only. `tblRdData` shows entry `tblAddr` combinationally, and addresses 0, 14 and 15 read as zero.
- R7: While the state is steady, `gateOut` equals the table entry for `stateOut` one cycle after the table holds it. This includes rewrites made while the block is running.
- R8: When the target state differs and `deadTime` is nonzero, `gateOut` becomes old AND new for exactly `deadTime` cycles. `gateOut` then becomes the new pattern and `stateOut` takes the new state. The block does not sample another change until that commit is done.
- R9: When `deadTime` is 0, a state change updates `stateOut` and `gateOut` to the new pattern on the same edge.
- R10: At full amplitude the staircase reaches both +6 and -6 within one reference period. At zero amplitude it stays in state 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phaseInc | input | PHASE_W | Phase step added each clock |
| amplitude | input | AMP_W | Reference scale, 2^(AMP_W-1) is full scale |
| deadTime | input | DT_W | Blanking length in clocks for each state change |
| tblAddr | input | 4 | Pattern table entry (state number) |
| tblWrData | input | 14 | Pattern to write |
| tblWe | input | 1 | Pattern write enable |
| tblRdData | output | 14 | Pattern stored at `tblAddr` |
| gateOut | output | 14 | Gate drive, bit n drives switch n+1 |
| stateOut | output | 4 | Committed switching state 1..13 |
| levelOut | output | 4 | Signed selected level -6..+6 |

## Verification
The phase register is updated on the edge where the increment is seen. The level follows one edge after the phase that produced it, and the state and gates follow one edge after the level. With a dead time of D, the blended gate vector appears on that same edge and lasts D cycles before the commit. Table readback is combinational, so it is due in the same cycle as the address. The reference model advances on every rising edge from the inputs the bench drives. It is compared against every output at the following falling edge, so each result is checked exactly in the cycle it falls due.

// File: rtl/staircase_pkg.sv
package staircase_pkg;
  localparam int NUM_SW     = 14;
  localparam int NUM_STATES = 13;
  localparam int MAX_LEVEL  = 6;
  localparam int ZERO_STATE = 7;
  localparam int STATE_W    = 4;
  localparam int LEVEL_W    = 4;

  typedef struct packed {
    logic loadPend;      // latch target, blank changing gates
    logic commitPend;    // dead time over, apply latched state
    logic commitDirect;  // no dead time, apply target at once
    logic refresh;       // steady state, track the table
    logic holding;       // dead-time window active
  } ctlStrobes_t;

  function automatic int quarterSine(int idx, int qn, int scale);
    real ang;
    ang = 3.141592653589793 * (2.0 * $itor(idx) + 1.0) / (4.0 * $itor(qn));
    return $rtoi($itor(scale) * $sin(ang));
  endfunction
endpackage

// File: rtl/staircase_ctrl.sv
module staircase_ctrl
  import staircase_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            changeReq,
  input  logic [DT_W-1:0] deadTime,
  output ctlStrobes_t     strobes
);
  logic            holding;
  logic [DT_W-1:0] dtCnt;

  always_comb begin
    strobes = '0;
    strobes.holding = holding;
    if (holding) begin
      strobes.commitPend = (dtCnt == DT_W'(1));
    end else if (changeReq) begin
      strobes.commitDirect = (deadTime == '0);
      strobes.loadPend     = (deadTime != '0);
    end else begin
      strobes.refresh = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      holding <= 1'b0;
      dtCnt   <= '0;
    end else if (holding) begin
      if (dtCnt == DT_W'(1)) holding <= 1'b0;
      dtCnt <= dtCnt - DT_W'(1);
    end else if (changeReq && deadTime != '0) begin
      holding <= 1'b1;
      dtCnt   <= deadTime;
    end
  end

  // R9: a zero dead time never opens a blanking window
  a_r9_no_hold_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(deadTime) == '0 && !$past(holding)) |-> !holding);
  // R8: the window count is never zero while blanking
  a_r8_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    holding |-> dtCnt != '0);
endmodule

// File: rtl/staircase_dp.sv
module staircase_dp
  import staircase_pkg::*;
#(
  parameter int PHASE_W = 24,
  parameter int LUT_AW  = 6,
  parameter int SAMP_W  = 12,
  parameter int AMP_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [PHASE_W-1:0]        phaseInc,
  input  logic [AMP_W-1:0]          amplitude,
  input  ctlStrobes_t               strobes,
  input  logic [STATE_W-1:0]        tblAddr,
  input  logic [NUM_SW-1:0]         tblWrData,
  input  logic                      tblWe,
  output logic [NUM_SW-1:0]         tblRdData,
  output logic [NUM_SW-1:0]         gates,
  output logic [STATE_W-1:0]        curState,
  output logic signed [LEVEL_W-1:0] level,
  output logic                      changeReq
);
  localparam int QN     = 1 << LUT_AW;
  localparam int MAG_W  = SAMP_W - 1;
  localparam int SHIFT  = MAG_W + AMP_W - 1;
  localparam int PROD_W = MAG_W + AMP_W + 5;

  logic [PHASE_W-1:0] phaseAcc;
  logic [MAG_W-1:0]   sineRom [QN];

  for (genvar g = 0; g < QN; g++) begin : g_rom
    assign sineRom[g] = MAG_W'(quarterSine(g, QN, 1 << MAG_W));
  end

  logic [1:0]        quad;
  logic [LUT_AW-1:0] romAddr, romIdx;
  logic [PROD_W-1:0] prod, rounded;
  logic [LEVEL_W-1:0] magLvl;
  logic signed [LEVEL_W-1:0] levelNext;

  always_comb begin
    quad    = phaseAcc[PHASE_W-1 -: 2];
    romAddr = phaseAcc[PHASE_W-3 -: LUT_AW];
    romIdx  = quad[0] ? ~romAddr : romAddr;
    prod    = PROD_W'(sineRom[romIdx]) * PROD_W'(amplitude) * PROD_W'(12);
    rounded = (prod + (PROD_W'(1) << SHIFT)) >> (SHIFT + 1);
    magLvl  = (rounded > PROD_W'(MAX_LEVEL)) ? LEVEL_W'(MAX_LEVEL) : LEVEL_W'(rounded);
    levelNext = quad[1] ? -$signed(magLvl) : $signed(magLvl);
  end

  logic [STATE_W-1:0] targetState, pendState;
  always_comb begin
    if (level > 0)      targetState = STATE_W'(level);
    else if (level < 0) targetState = STATE_W'(ZERO_STATE) + STATE_W'(-level);
    else                targetState = STATE_W'(ZERO_STATE);
  end
  assign changeReq = (targetState != curState);

  logic [NUM_SW-1:0] gateTbl [16];
  assign tblRdData = gateTbl[tblAddr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) gateTbl[i] <= '0;
    end else if (tblWe && tblAddr >= STATE_W'(1) && tblAddr <= STATE_W'(NUM_STATES)) begin
      gateTbl[tblAddr] <= tblWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phaseAcc  <= '0;
      level     <= '0;
      curState  <= STATE_W'(ZERO_STATE);
      pendState <= STATE_W'(ZERO_STATE);
      gates     <= '0;
    end else begin
      phaseAcc <= phaseAcc + phaseInc;
      level    <= levelNext;
      if (strobes.commitDirect) begin
        curState <= targetState;
        gates    <= gateTbl[targetState];
      end else if (strobes.loadPend) begin
        pendState <= targetState;
        gates     <= gateTbl[curState] & gateTbl[targetState];
      end else if (strobes.commitPend) begin
        curState <= pendState;
        gates    <= gateTbl[pendState];
      end else if (strobes.refresh) begin
        gates <= gateTbl[curState];
      end
    end
  end

  a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> phaseAcc == PHASE_W'($past(phaseAcc) + $past(phaseInc)));
  a_r4_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (level >= -LEVEL_W'(MAX_LEVEL)) && (level <= LEVEL_W'(MAX_LEVEL)));
  a_r5_state_range: assert property (@(posedge clk) disable iff (!rst_n)
    curState >= STATE_W'(1) && curState <= STATE_W'(NUM_STATES));
  a_r7_state_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(strobes.commitPend) && !$past(strobes.commitDirect))
      |-> $stable(curState));
  a_r8_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && strobes.holding && $past(strobes.holding)) |-> $stable(gates));
endmodule

// File: rtl/staircase_gate_ctrl.sv
module staircase_gate_ctrl
  import staircase_pkg::*;
#(
  parameter int PHASE_W = 24,
  parameter int LUT_AW  = 6,
  parameter int SAMP_W  = 12,
  parameter int AMP_W   = 8,
  parameter int DT_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [PHASE_W-1:0]        phaseInc,
  input  logic [AMP_W-1:0]          amplitude,
  input  logic [DT_W-1:0]           deadTime,
  input  logic [3:0]                tblAddr,
  input  logic [13:0]               tblWrData,
  input  logic                      tblWe,
  output logic [13:0]               tblRdData,
  output logic [13:0]               gateOut,
  output logic [3:0]                stateOut,
  output logic signed [3:0]         levelOut
);
  ctlStrobes_t strobes;
  logic        changeReq;

  staircase_ctrl #(.DT_W(DT_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .changeReq(changeReq),
    .deadTime(deadTime), .strobes(strobes)
  );

  staircase_dp #(.PHASE_W(PHASE_W), .LUT_AW(LUT_AW), .SAMP_W(SAMP_W), .AMP_W(AMP_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .phaseInc(phaseInc), .amplitude(amplitude),
    .strobes(strobes), .tblAddr(tblAddr), .tblWrData(tblWrData), .tblWe(tblWe),
    .tblRdData(tblRdData), .gates(gateOut), .curState(stateOut),
    .level(levelOut), .changeReq(changeReq)
  );
endmodule

// File: tb/test_staircase_gate_ctrl.sv
module test_staircase_gate_ctrl;
  localparam int PW = 24;
  logic clk = 0;
  logic rst_n = 0;
  logic [PW-1:0] phaseInc = '0;
  logic [7:0] amplitude = '0;
  logic [7:0] deadTime = '0;
  logic [3:0] tblAddr = '0;
  logic [13:0] tblWrData = '0;
  logic tblWe = 0;
  logic [13:0] tblRdData, gateOut;
  logic [3:0] stateOut;
  logic signed [3:0] levelOut;

  staircase_gate_ctrl i_staircase_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .phaseInc(phaseInc), .amplitude(amplitude),
    .deadTime(deadTime), .tblAddr(tblAddr), .tblWrData(tblWrData), .tblWe(tblWe),
    .tblRdData(tblRdData), .gateOut(gateOut), .stateOut(stateOut), .levelOut(levelOut)
  );

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural reference model
  int mAcc, mLvl, mCur, mPend, mCnt, mGate;
  bit mHold;
  int mTbl [16];
  int minLvl, maxLvl, holdCycles;

  function automatic int levelOf(int acc, int amp);
    int quad, a, idx, m, r;
    real x;
    quad = (acc >> 22) & 3;
    a = (acc >> 16) & 63;
    idx = (quad % 2 == 1) ? 63 - a : a;
    m = $rtoi(2048.0 * $sin(3.141592653589793 * (2.0 * idx + 1.0) / 256.0));
    x = $itor(m) * $itor(amp) * 6.0 / 262144.0;
    r = $rtoi($floor(x + 0.5));
    if (r > 6) r = 6;
    return (quad >= 2) ? -r : r;
  endfunction

  function automatic int stateOf(int lvl);
    if (lvl > 0) return lvl;
    if (lvl == 0) return 7;
    return 7 - lvl;
  endfunction

  always @(posedge clk) begin
    int tgt;
    if (!rst_n) begin
      mAcc = 0; mLvl = 0; mCur = 7; mPend = 7; mCnt = 0; mHold = 0; mGate = 0;
      for (int i = 0; i < 16; i++) mTbl[i] = 0;
    end else begin
      tgt = stateOf(mLvl);
      if (mHold) begin
        if (mCnt == 1) begin mHold = 0; mCur = mPend; mGate = mTbl[mPend]; end
        mCnt = mCnt - 1;
      end else if (tgt != mCur) begin
        if (deadTime == 0) begin mCur = tgt; mGate = mTbl[tgt]; end
        else begin
          mPend = tgt; mGate = mTbl[mCur] & mTbl[tgt];
          mHold = 1; mCnt = deadTime;
        end
      end else mGate = mTbl[mCur];
      mLvl = levelOf(mAcc, amplitude);
      mAcc = (mAcc + phaseInc) & 24'hFFFFFF;
      if (tblWe && tblAddr >= 1 && tblAddr <= 13) mTbl[tblAddr] = tblWrData;
    end
  end

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-clock comparison at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(mHold ? "R8" : "R7", gateOut, mGate, "gateOut");
      check("R5", stateOut, mCur, "stateOut");
      check("R3", levelOut, mLvl, "levelOut");
      if (levelOut < minLvl) minLvl = levelOut;
      if (levelOut > maxLvl) maxLvl = levelOut;
      if (mHold) holdCycles++;
    end
  end

  function automatic int pattern(int s);
    int p;
    p = ((s * 16'h02F3) ^ (s << 7)) & 14'h3FFF;
    if (s == 2) p = (1 << 3) | (1 << 10);      // S4 and S11
    if (s == 3) p = (1 << 2) | (1 << 3);       // S3 and S4
    if (s == 5 || s == 9 || s == 12) p = p | 14'h000C;
    return p;
  endfunction

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeTbl(int a, int d);
    @(negedge clk);
    tblAddr = 4'(a); tblWrData = 14'(d); tblWe = 1;
    @(negedge clk);
    tblWe = 0;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", gateOut, 0, "gateOut in reset");
    check("R1", stateOut, 7, "stateOut in reset");
    check("R1", levelOut, 0, "levelOut in reset");
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R1", gateOut, 0, "gateOut after reset");
    // R6: program and read back the pattern table
    for (int s = 0; s < 16; s++) writeTbl(s, pattern(s));
    for (int s = 0; s < 16; s++) begin
      tblAddr = 4'(s); #1;
      check("R6", tblRdData, (s >= 1 && s <= 13) ? pattern(s) : 0, "tblRdData");
    end
    check("R6", tblRdData & 14'h000C, 0, "addr15 ignored");
    // R10/R8: full amplitude, dead time 3, one period
    minLvl = 0; maxLvl = 0; holdCycles = 0;
    deadTime = 3; amplitude = 128; phaseInc = 24'd4096;
    cycles(4200);
    check("R10", maxLvl, 6, "max level full scale");
    check("R10", minLvl, -6, "min level full scale");
    check("R8", (holdCycles > 0) ? 1 : 0, 1, "dead-time windows seen");
    // R4/R9: saturating amplitude, no dead time
    minLvl = 0; maxLvl = 0; holdCycles = 0;
    deadTime = 0; amplitude = 255; phaseInc = 24'd5000;
    cycles(4000);
    check("R4", maxLvl, 6, "saturated top");
    check("R4", minLvl, -6, "saturated bottom");
    check("R9", holdCycles, 0, "no blanking at zero dead time");
    // R10: zero amplitude stays in state 7; R7 live table rewrite
    amplitude = 0; deadTime = 2;
    cycles(300);
    check("R10", stateOut, 7, "zero amplitude state");
    writeTbl(7, 14'h2A55);
    cycles(3);
    check("R7", gateOut, 14'h2A55, "rewrite of active entry");
    // R2/R3/R8: partial amplitude, longer dead time, other step
    amplitude = 64; deadTime = 5; phaseInc = 24'd3001;
    cycles(6000);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule